// File: doc/BRIEF.md
# Branch Direction Predictor with Compiler Hints

This block gives the fetch stage of a simple in-order pipeline a taken or not-taken guess for each conditional branch. Fetch presents the branch's own address, its computed target address and an optional hint from the instruction encoding. Two clock cycles later the block returns a registered prediction, together with a code that names the source that decided it.

Three sources are ranked. The first is a small direct-mapped table of recently resolved branches, used when its entry is valid and the tag matches. The second is a valid compiler hint. The last is a static rule: a branch that jumps to a lower address is taken as a loop and predicted taken, and every other branch is predicted not taken.

When a branch resolves, the execute stage sends the branch address and the real outcome. The entry that the address selects is then rewritten with the new tag and direction, so each entry always holds the most recent outcome of whichever branch last used it.

Top module: `brdir_predictor`

## Requirements
- R1: Reset clears every table entry, so a lookup made after reset never reports a table hit until an update writes that entry again.
- R2: A lookup accepted on a rising edge produces `pred_valid` high in the cycle after the next rising edge, which is two edges of latency. `pred_valid` is low in all other cycles, and when it is low both `pred_taken` and `pred_source` read 0.
- R3: With no table hit and no valid hint, the prediction is taken when the target is strictly lower than the branch address. Otherwise it is not taken, including when the two addresses are equal. `pred_source` = 2'b00.
- R4: With no table hit and `hint_valid` high, the prediction equals `hint_taken`, whichever way the branch points. `pred_source` = 2'b01.
- R5: A table hit overrides both the hint and the static rule. The prediction is the stored direction and `pred_source` = 2'b10.
- R6: The table index is address bits [5:2] and the tag is address bits [11:6]. A branch with the same index but a different tag misses.
- R7: Every resolution with `update_valid` high writes its entry with the new tag and outcome, replacing whatever the entry held before.
- R8: When a lookup and an update select the same entry in the same cycle, the update is stored and the lookup sees the entry's contents from before that update.
- R9: `pred_source` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | A branch is presented for prediction |
| lookup_pc | input | AW | Address of the branch being predicted |
| lookup_target | input | AW | Target address of that branch |
| hint_valid | input | 1 | The instruction carries a direction hint |
| hint_taken | input | 1 | Direction the hint gives, 1 = taken |
| update_valid | input | 1 | A branch has resolved |
| update_pc | input | AW | Address of the resolved branch |
| update_taken | input | 1 | Actual outcome, 1 = taken |
| pred_valid | output | 1 | Prediction is present this cycle |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_source | output | 2 | 00 static rule, 01 hint, 10 table |

## Verification
The assertions check, on every cycle, the two-cycle relation between `lookup_valid` and `pred_valid` and the all-zero outputs in idle cycles. They also check that the source code is always legal, that a hint-sourced prediction copies the hint of two cycles earlier, and that a static prediction follows the address comparison and occurs only when no hint was present. Which entry a branch maps to, whether it hits, and what it holds depend on the history of updates, so only the bench's scenarios can show them. Those scenarios cover table priority over the hint, tag aliasing, replacement, the same-cycle update and lookup, and the clearing done by reset.

// File: rtl/brdir_pkg.sv
package brdir_pkg;
  // Which of the three ranked sources decided a prediction.
  typedef enum logic [1:0] {
    SRC_STATIC = 2'b00,
    SRC_HINT   = 2'b01,
    SRC_TABLE  = 2'b10
  } src_e;
endpackage

// File: rtl/brdir_table.sv
// Direct-mapped history store. Tag and direction live in a memory with a
// registered, read-first port, so it can map onto block RAM. Valid bits sit
// in flops so that reset can clear them all at once.
module brdir_table #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dir,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_dir
);
  logic [TAG_W:0]       mem [ENTRIES];
  logic [ENTRIES-1:0]   vld;
  logic [TAG_W:0]       rd_word;

  // Memory port: read and write in the same process. The nonblocking write
  // means a read of the same entry returns the old contents.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_dir};
    if (rd_en) rd_word <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= vld[rd_idx];
    end
  end

  assign rd_tag = rd_word[TAG_W:1];
  assign rd_dir = rd_word[0];
endmodule

// File: rtl/brdir_select.sv
// Ranks the three sources: a table hit first, then a valid hint, then the
// backward-taken rule.
module brdir_select
  import brdir_pkg::*;
(
  input  logic hit,
  input  logic hit_dir,
  input  logic hint_v,
  input  logic hint_dir,
  input  logic backward,
  output logic taken,
  output src_e source
);
  always_comb begin
    if (hit) begin
      taken  = hit_dir;
      source = SRC_TABLE;
    end else if (hint_v) begin
      taken  = hint_dir;
      source = SRC_HINT;
    end else begin
      taken  = backward;
      source = SRC_STATIC;
    end
  end
endmodule

// File: rtl/brdir_predictor.sv
module brdir_predictor
  import brdir_pkg::*;
#(
  parameter int AW      = 32,
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 6,
  parameter int ALIGN   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lookup_valid,
  input  logic [AW-1:0] lookup_pc,
  input  logic [AW-1:0] lookup_target,
  input  logic          hint_valid,
  input  logic          hint_taken,
  input  logic          update_valid,
  input  logic [AW-1:0] update_pc,
  input  logic          update_taken,
  output logic          pred_valid,
  output logic          pred_taken,
  output logic [1:0]    pred_source
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int IDX_LO = ALIGN;
  localparam int TAG_LO = ALIGN + IDX_W;
  localparam int TAG_HI = TAG_LO + TAG_W - 1;

  // Address slices
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_idx = lookup_pc[TAG_LO-1:IDX_LO];
  assign lk_tag = lookup_pc[TAG_HI:TAG_LO];
  assign up_idx = update_pc[TAG_LO-1:IDX_LO];
  assign up_tag = update_pc[TAG_HI:TAG_LO];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{lookup_pc[AW-1:TAG_HI+1], lookup_pc[ALIGN-1:0],
                              update_pc[AW-1:TAG_HI+1], update_pc[ALIGN-1:0]};

  // Stage 1: table read alongside the captured lookup fields
  logic             t_valid, t_dir;
  logic [TAG_W-1:0] t_tag;

  brdir_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (lookup_valid),
    .rd_idx   (lk_idx),
    .wr_en    (update_valid),
    .wr_idx   (up_idx),
    .wr_tag   (up_tag),
    .wr_dir   (update_taken),
    .rd_valid (t_valid),
    .rd_tag   (t_tag),
    .rd_dir   (t_dir)
  );

  logic             s1_valid, s1_hint_v, s1_hint_t, s1_back;
  logic [TAG_W-1:0] s1_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_hint_v <= 1'b0;
      s1_hint_t <= 1'b0;
      s1_back   <= 1'b0;
      s1_tag    <= '0;
    end else begin
      s1_valid <= lookup_valid;
      if (lookup_valid) begin
        s1_hint_v <= hint_valid;
        s1_hint_t <= hint_taken;
        s1_back   <= (lookup_target < lookup_pc);
        s1_tag    <= lk_tag;
      end
    end
  end

  // Stage 2: resolve priority and register the result
  logic sel_taken, hit;
  src_e sel_src;
  assign hit = t_valid && (t_tag == s1_tag);

  brdir_select u_select (
    .hit      (hit),
    .hit_dir  (t_dir),
    .hint_v   (s1_hint_v),
    .hint_dir (s1_hint_t),
    .backward (s1_back),
    .taken    (sel_taken),
    .source   (sel_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_taken  <= 1'b0;
      pred_source <= SRC_STATIC;
    end else begin
      pred_valid  <= s1_valid;
      pred_taken  <= s1_valid ? sel_taken : 1'b0;
      pred_source <= s1_valid ? sel_src : SRC_STATIC;
    end
  end
endmodule

// File: rtl/brdir_checker.sv
module brdir_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          lookup_valid,
  input logic [AW-1:0] lookup_pc,
  input logic [AW-1:0] lookup_target,
  input logic          hint_valid,
  input logic          hint_taken,
  input logic          pred_valid,
  input logic          pred_taken,
  input logic [1:0]    pred_source
);
  // Edges seen since reset, saturating; guards every two-cycle look back.
  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2) |-> (pred_valid == $past(lookup_valid, 2)));

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |-> (!pred_taken && pred_source == 2'b00));

  p_code_legal_r9: assert property (@(posedge clk) disable iff (rst)
    pred_source != 2'b11);

  p_hint_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && pred_valid && pred_source == 2'b01)
      |-> ($past(hint_valid, 2) && pred_taken == $past(hint_taken, 2)));

  p_static_rule_r3: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && pred_valid && pred_source == 2'b00)
      |-> (!$past(hint_valid, 2) &&
           pred_taken == $past(lookup_target < lookup_pc, 2)));
endmodule

bind brdir_predictor brdir_checker #(.AW(AW)) u_checker (
  .clk           (clk),
  .rst           (rst),
  .lookup_valid  (lookup_valid),
  .lookup_pc     (lookup_pc),
  .lookup_target (lookup_target),
  .hint_valid    (hint_valid),
  .hint_taken    (hint_taken),
  .pred_valid    (pred_valid),
  .pred_taken    (pred_taken),
  .pred_source   (pred_source)
);

// File: tb/brdir_predictor_test.sv
`timescale 1ns/1ps
module brdir_predictor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookup_valid = 1'b0, hint_valid = 1'b0, hint_taken = 1'b0;
  logic [31:0] lookup_pc = '0, lookup_target = '0, update_pc = '0;
  logic        update_valid = 1'b0, update_taken = 1'b0;
  logic        pred_valid, pred_taken;
  logic [1:0]  pred_source;

  always #2 clk = ~clk;   // 250 MHz

  brdir_predictor uut (
    .clk(clk), .rst(rst), .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
    .lookup_target(lookup_target), .hint_valid(hint_valid), .hint_taken(hint_taken),
    .update_valid(update_valid), .update_pc(update_pc), .update_taken(update_taken),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_source(pred_source)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  typedef struct { int due; logic taken; logic [1:0] src; string req; } exp_t;
  exp_t sb[$];

  // Requirement model: index pc[5:2], tag pc[11:6]
  bit       m_val [16];
  bit [5:0] m_tag [16];
  bit       m_dir [16];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Drive one cycle: optional lookup and optional update.
  task automatic step(input bit lv, input logic [31:0] pc, input logic [31:0] tgt,
                      input bit hv, input bit ht, input bit uv,
                      input logic [31:0] upc, input bit ut, input string req);
    exp_t e;
    @(negedge clk);
    lookup_valid = lv; lookup_pc = pc; lookup_target = tgt;
    hint_valid = hv; hint_taken = ht;
    update_valid = uv; update_pc = upc; update_taken = ut;
    if (lv) begin
      e.due = cyc + 2; e.req = req;
      if (m_val[pc[5:2]] && m_tag[pc[5:2]] == pc[11:6]) begin
        e.taken = m_dir[pc[5:2]]; e.src = 2'b10;
      end else if (hv) begin
        e.taken = ht; e.src = 2'b01;
      end else begin
        e.taken = (tgt < pc); e.src = 2'b00;
      end
      sb.push_back(e);
    end
    // Model update after the lookup was resolved: old value seen (R8)
    if (uv) begin
      m_val[upc[5:2]] = 1'b1; m_tag[upc[5:2]] = upc[11:6]; m_dir[upc[5:2]] = ut;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    lookup_valid = 0; update_valid = 0; hint_valid = 0;
    for (int i = 0; i < 16; i++) m_val[i] = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: compare results against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (pred_valid) begin
        if (sb.size() == 0) begin
          chk(0, "R2 unexpected prediction", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.due == cyc, {e.req, " R2 latency"}, cyc, e.due);
          chk(pred_taken == e.taken, {e.req, " direction"}, pred_taken, e.taken);
          chk(pred_source == e.src, {e.req, " source"}, pred_source, e.src);
          chk(pred_source != 2'b11, "R9 source code", pred_source, 0);
        end
      end else begin
        chk(pred_taken == 0 && pred_source == 0, "R2 idle outputs",
            {pred_taken, pred_source}, 0);
        if (sb.size() != 0 && sb[0].due <= cyc)
          chk(0, {sb[0].req, " R2 missing prediction"}, 0, 1);
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_val[i] = 0; m_tag[i] = 0; m_dir[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pred_valid == 0 && pred_taken == 0 && pred_source == 0, "R1 reset state",
        {pred_valid, pred_taken, pred_source}, 0);

    // R3 static rule: backward, forward, equal
    step(1, 32'h100, 32'h080, 0, 0, 0, 0, 0, "R3 backward");
    step(1, 32'h100, 32'h200, 0, 0, 0, 0, 0, "R3 forward");
    step(1, 32'h100, 32'h100, 0, 0, 0, 0, 0, "R3 equal");
    // R4 hint overrides static in both directions
    step(1, 32'h104, 32'h080, 1, 0, 0, 0, 0, "R4 hint not-taken on backward");
    step(1, 32'h108, 32'h300, 1, 1, 0, 0, 0, "R4 hint taken on forward");
    idle(3);

    // R5 table hit overrides hint and static
    step(0, 0, 0, 0, 0, 1, 32'h100, 0, "");
    step(1, 32'h100, 32'h080, 1, 1, 0, 0, 0, "R5 table beats hint and static");
    // R6 same index (0), different tag (5): miss
    step(1, 32'h140, 32'h080, 0, 0, 0, 0, 0, "R6 alias tag miss");
    idle(3);

    // R7 latest outcome replaces the entry
    step(0, 0, 0, 0, 0, 1, 32'h100, 1, "");
    step(1, 32'h100, 32'h200, 1, 0, 0, 0, 0, "R7 rewritten direction");
    step(0, 0, 0, 0, 0, 1, 32'h140, 0, "");
    step(1, 32'h100, 32'h080, 1, 1, 0, 0, 0, "R7 entry replaced by other tag");
    step(1, 32'h140, 32'h080, 0, 0, 0, 0, 0, "R7 new owner hits");
    idle(3);

    // R8 same-cycle lookup and update of one entry: old contents seen
    step(1, 32'h10C, 32'h400, 0, 0, 1, 32'h10C, 1, "R8 same-cycle old value");
    step(1, 32'h10C, 32'h400, 0, 0, 0, 0, 0, "R8 update visible next");
    idle(3);

    // R1 reset clears the table
    step(0, 0, 0, 0, 0, 1, 32'h13C, 1, "");
    idle(2);
    do_reset();
    step(1, 32'h13C, 32'h500, 0, 0, 0, 0, 0, "R1 entry cleared by reset");
    idle(4);

    chk(sb.size() == 0, "R2 all predictions delivered", sb.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule